// File: doc/BRIEF.md
# GPIO Output and Interrupt Control Registers

This block is a byte-addressed control register file for a companion I/O device. It stores a general-purpose output data vector and an output-enable (direction) vector. Each vector is three byte lanes wide, and only the low 16 bits reach pins. A pin's effective level is its data bit gated by its enable bit. The block registers that level onto the pin outputs and emits a one-cycle change pulse for every pin whose gated level toggles.

The same register file gathers eight internal sub-interrupt lines into a status byte. The lines are NAND controller, MMC, USB host, serial, framebuffer, and three spares. The status byte is combined with a mask byte to produce a single host interrupt. There is also a routing byte that software can read and write, and a fixed revision byte.

Software uses a plain synchronous register bus. Each cycle carries one byte write or one byte read, and read data is returned one cycle after the read strobe. There is no flow control and no stream interface: every access completes in a single cycle.

Top module: `gpio_irq_regs`

## Requirements
- R1: While reset is asserted, and after it is released, all data, enable, status, mask and routing registers read 0x00, `pin_level` and `pin_chg` are zero, and `host_irq` is low.
- R2: Offset 0x08 reads the parameter `REV_ID` (default 0x3C), and writes to 0x08 leave it unchanged.
- R3: A write to 0x78+i (i = 0..2) replaces bits 8i+7..8i of the data vector. A write to 0x7C+i does the same for the enable vector. Every other lane keeps its value, and each lane reads back at its own offset.
- R4: Lane 2 (offsets 0x7A and 0x7E) stores and reads back its byte but never affects `pin_level` or `pin_chg`.
- R5: `pin_level` equals (data AND enable)[15:0] as held one cycle earlier. It therefore changes on the second clock edge after the write strobe is sampled.
- R6: `pin_chg[k]` is high for exactly one cycle, in the same cycle that `pin_level[k]` changes, and is never high when the gated level is unchanged. A data change on a disabled pin gives no pulse.
- R7: Status bit n (read at 0x50) equals sub-interrupt line n as sampled on the previous edge. Writes to 0x50 are ignored.
- R8: `host_irq` is high exactly when (status AND mask) is non-zero. The mask is read and written at 0x52.
- R9: The routing byte at 0x54 is read/write and has no other effect.
- R10: Reads of any other offset return 0x00, and writes to them change no register.
- R11: `rd_data` shows the addressed byte in the cycle after `rd_en` is sampled. It shows 0x00 after a cycle without a read. A read in the same cycle as a write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read byte, registered |
| sub_irq | input | 8 | Sub-interrupt lines (0 NAND, 1 MMC, 2 USB host, 3 serial, 4 framebuffer) |
| host_irq | output | 1 | Masked host interrupt |
| pin_level | output | 16 | Gated output level per pin |
| pin_chg | output | 16 | One-cycle toggle pulse per pin |

## Verification
Result timing is fixed and counted from the edge that samples a stimulus:
- A register write is visible to a read strobed on the next edge, and that read's data appears one cycle later.
- `pin_level` and `pin_chg` move on the edge after the register write takes effect.
- A sub-interrupt line reaches the status bit, and through it `host_irq`, one edge after it is sampled.

The bench drives inputs on falling edges. A behavioural reference model steps on each rising edge, and every output is compared against it at each falling edge. Directed checks sample exactly those later falling edges.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] OFS_REV    = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h50;
  localparam logic [7:0] OFS_MASK   = 8'h52;
  localparam logic [7:0] OFS_ROUTE  = 8'h54;
  localparam logic [7:0] OFS_DATA   = 8'h78;
  localparam logic [7:0] OFS_OE     = 8'h7C;

  function automatic logic in_window(input logic [7:0] a, input logic [7:0] base,
                                     input int lanes);
    return (a >= base) && (int'(a) < int'(base) + lanes);
  endfunction
endpackage

// File: rtl/gir_lane_reg.sv
module gir_lane_reg #(
  parameter int LANES = 3,
  parameter logic [7:0] BASE = 8'h78,
  localparam int W = 8 * LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [7:0]   addr,
  input  logic [7:0]   wdata,
  output logic [W-1:0] value
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [7:0] LANE_ADDR = BASE + 8'(g);
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (wr_en && addr == LANE_ADDR)
        lane_q <= wdata;
    end
    assign value[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/gir_pin_tracker.sv
module gir_pin_tracker #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] data,
  input  logic [PINS-1:0] oe,
  output logic [PINS-1:0] level,
  output logic [PINS-1:0] chg
);
  logic [PINS-1:0] gated;
  assign gated = data & oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      chg   <= '0;
    end else begin
      chg   <= level ^ gated;
      level <= gated;
    end
  end
endmodule

// File: rtl/gir_irq_gather.sv
module gir_irq_gather #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] mask,
  output logic [LINES-1:0] status,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= lines;
  end
  assign irq = |(status & mask);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gir_pkg::*;
#(
  parameter int PINS = 16,
  parameter int LANES = 3,
  parameter int IRQ_LINES = 8,
  parameter logic [7:0] REV_ID = 8'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  input  logic [7:0]  sub_irq,
  output logic        host_irq,
  output logic [15:0] pin_level,
  output logic [15:0] pin_chg
);
  localparam int VEC_W = 8 * LANES;

  logic [VEC_W-1:0] data_vec, oe_vec;
  logic [IRQ_LINES-1:0] status, mask_q;
  logic [7:0] route_q;
  logic [7:0] rd_mux;

  gir_lane_reg #(.LANES(LANES), .BASE(OFS_DATA)) u_data (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(wr_data), .value(data_vec));

  gir_lane_reg #(.LANES(LANES), .BASE(OFS_OE)) u_oe (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(wr_data), .value(oe_vec));

  gir_pin_tracker #(.PINS(PINS)) u_pins (
    .clk(clk), .rst_n(rst_n), .data(data_vec[PINS-1:0]),
    .oe(oe_vec[PINS-1:0]), .level(pin_level), .chg(pin_chg));

  gir_irq_gather #(.LINES(IRQ_LINES)) u_irq (
    .clk(clk), .rst_n(rst_n), .lines(sub_irq), .mask(mask_q),
    .status(status), .irq(host_irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == OFS_MASK)  mask_q  <= wr_data;
      if (bus_addr == OFS_ROUTE) route_q <= wr_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_REV)         rd_mux = REV_ID;
    else if (bus_addr == OFS_STATUS) rd_mux = status;
    else if (bus_addr == OFS_MASK)   rd_mux = mask_q;
    else if (bus_addr == OFS_ROUTE)  rd_mux = route_q;
    else if (in_window(bus_addr, OFS_DATA, LANES))
      rd_mux = data_vec[8*int'(bus_addr - OFS_DATA) +: 8];
    else if (in_window(bus_addr, OFS_OE, LANES))
      rd_mux = oe_vec[8*int'(bus_addr - OFS_OE) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/gpio_irq_regs_checks.sv
module gpio_irq_regs_checks #(
  parameter logic [7:0] REV_ID = 8'h3C
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        rd_en,
  input logic [7:0]  rd_data,
  input logic [7:0]  sub_irq,
  input logic [7:0]  status,
  input logic [7:0]  mask_q,
  input logic        host_irq,
  input logic [23:0] data_vec,
  input logic [23:0] oe_vec,
  input logic [15:0] pin_level,
  input logic [15:0] pin_chg
);
  logic unmapped;
  assign unmapped = !(bus_addr == 8'h08 || bus_addr == 8'h50 || bus_addr == 8'h52 ||
                      bus_addr == 8'h54 || (bus_addr >= 8'h78 && bus_addr <= 8'h7A) ||
                      (bus_addr >= 8'h7C && bus_addr <= 8'h7E));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (pin_level == '0 && pin_chg == '0 && !host_irq && rd_data == '0));

  a_r2_rev_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == 8'h08) |=> rd_data == REV_ID);

  a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pin_level == $past(data_vec[15:0] & oe_vec[15:0]));

  a_r6_pulse_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pin_chg == (pin_level ^ $past(pin_level)));

  a_r7_status_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status == $past(sub_irq));

  a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ((sub_irq & mask_q) != '0) |=> (host_irq || !$stable(mask_q)));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> rd_data == '0);
endmodule

bind gpio_irq_regs gpio_irq_regs_checks #(.REV_ID(REV_ID)) u_checks (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en), .rd_data(rd_data),
  .sub_irq(sub_irq), .status(status), .mask_q(mask_q), .host_irq(host_irq),
  .data_vec(data_vec), .oe_vec(oe_vec), .pin_level(pin_level), .pin_chg(pin_chg));

// File: tb/gpio_irq_regs_test.sv
`timescale 1ns/1ps
module gpio_irq_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0, wr_data = '0, sub_irq = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic host_irq;
  logic [15:0] pin_level, pin_chg;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sub_irq(sub_irq), .host_irq(host_irq),
    .pin_level(pin_level), .pin_chg(pin_chg));

  // reference model state
  int unsigned m_data = 0, m_oe = 0, m_lvl = 0, m_chg = 0;
  int unsigned m_stat = 0, m_mask = 0, m_route = 0, m_rd = 0;

  function automatic int unsigned model_read(input logic [7:0] a);
    if (a == 8'h08) return 32'h3C;
    if (a == 8'h50) return m_stat;
    if (a == 8'h52) return m_mask;
    if (a == 8'h54) return m_route;
    if (a >= 8'h78 && a <= 8'h7A) return (m_data >> (8 * (a - 8'h78))) & 32'hFF;
    if (a >= 8'h7C && a <= 8'h7E) return (m_oe >> (8 * (a - 8'h7C))) & 32'hFF;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_oe = 0; m_lvl = 0; m_chg = 0;
      m_stat = 0; m_mask = 0; m_route = 0; m_rd = 0;
    end else begin
      int unsigned g, sh;
      g = m_data & m_oe & 32'hFFFF;
      m_rd = rd_en ? model_read(bus_addr) : 0;
      m_chg = m_lvl ^ g;
      m_lvl = g;
      m_stat = sub_irq;
      if (wr_en) begin
        if (bus_addr == 8'h52) m_mask = wr_data;
        if (bus_addr == 8'h54) m_route = wr_data;
        if (bus_addr >= 8'h78 && bus_addr <= 8'h7A) begin
          sh = 8 * (bus_addr - 8'h78);
          m_data = (m_data & ~(32'hFF << sh)) | (32'(wr_data) << sh);
        end
        if (bus_addr >= 8'h7C && bus_addr <= 8'h7E) begin
          sh = 8 * (bus_addr - 8'h7C);
          m_oe = (m_oe & ~(32'hFF << sh)) | (32'(wr_data) << sh);
        end
      end
    end
  end

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 rd_data", rd_data, m_rd);
      check("R5 pin_level", pin_level, m_lvl);
      check("R6 pin_chg", pin_chg, m_chg);
      check("R8 host_irq", host_irq, ((m_stat & m_mask) != 0) ? 1 : 0);
    end
  end

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, exp);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pin_level in reset", pin_level, 0);
    check("R1 host_irq in reset", host_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 registers clear
    bus_read(8'h78, 8'h00, "R1 data lane0");
    bus_read(8'h7D, 8'h00, "R1 oe lane1");
    bus_read(8'h50, 8'h00, "R1 status");
    bus_read(8'h52, 8'h00, "R1 mask");
    bus_read(8'h54, 8'h00, "R1 route");
    // R2 revision fixed
    bus_read(8'h08, 8'h3C, "R2 rev");
    bus_write(8'h08, 8'hFF);
    bus_read(8'h08, 8'h3C, "R2 rev after write");
    // R3 byte lanes
    bus_write(8'h79, 8'hA5);
    bus_write(8'h78, 8'h3C);
    bus_read(8'h79, 8'hA5, "R3 data lane1 kept");
    bus_read(8'h78, 8'h3C, "R3 data lane0");
    check("R5 disabled pins low", pin_level, 0);
    // R5/R6 enable lane0
    bus_write(8'h7C, 8'h0F);
    check("R5 not yet", pin_level, 0);
    @(negedge clk);
    check("R5 gated level", pin_level, 16'h000C);
    check("R6 pulse", pin_chg, 16'h000C);
    @(negedge clk);
    check("R6 pulse one cycle", pin_chg, 0);
    // R6 disabled-pin data change: no pulse
    bus_write(8'h78, 8'hFC);
    @(negedge clk);
    check("R6 no pulse on disabled pin", pin_chg, 0);
    check("R6 level kept", pin_level, 16'h000C);
    bus_write(8'h7D, 8'hF0);
    @(negedge clk);
    check("R6 lane1 pulse", pin_chg, 16'hA000);
    check("R5 lane1 level", pin_level, 16'hA00C);
    bus_write(8'h79, 8'h05);
    @(negedge clk);
    check("R6 falling pulse", pin_chg, 16'hA000);
    check("R5 falling level", pin_level, 16'h000C);
    // R4 lane 2
    bus_write(8'h7A, 8'h77);
    bus_write(8'h7E, 8'hFF);
    @(negedge clk);
    check("R4 no pulse from lane2", pin_chg, 0);
    check("R4 level unchanged", pin_level, 16'h000C);
    bus_read(8'h7A, 8'h77, "R4 data lane2");
    bus_read(8'h7E, 8'hFF, "R4 oe lane2");
    bus_read(8'h79, 8'h05, "R3 lane1 unaffected by lane2");
    // R7 status
    sub_irq = 8'h12;
    idle();
    bus_read(8'h50, 8'h12, "R7 status");
    bus_write(8'h50, 8'hFF);
    bus_read(8'h50, 8'h12, "R7 status write ignored");
    // R8 mask
    check("R8 masked off", host_irq, 0);
    bus_write(8'h52, 8'h02);
    check("R8 raised", host_irq, 1);
    bus_write(8'h52, 8'h01);
    check("R8 masked", host_irq, 0);
    sub_irq = 8'h01;
    idle();
    check("R8 line rises", host_irq, 1);
    sub_irq = 8'h00;
    idle();
    check("R8 line falls", host_irq, 0);
    // R9 routing
    bus_write(8'h54, 8'h5A);
    bus_read(8'h54, 8'h5A, "R9 route");
    // R10 unmapped
    bus_read(8'h51, 8'h00, "R10 unmapped read");
    bus_write(8'h53, 8'hFF);
    bus_write(8'h7B, 8'hFF);
    bus_read(8'h52, 8'h01, "R10 mask unchanged");
    bus_read(8'h7B, 8'h00, "R10 gap read");
    bus_read(8'h7A, 8'h77, "R10 lane2 unchanged");
    // R11 read-during-write returns old value
    bus_addr = 8'h54; wr_data = 8'hC3; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11 read old value", rd_data, 8'h5A);
    @(negedge clk);
    check("R11 idle zero", rd_data, 0);
    bus_read(8'h54, 8'hC3, "R11 new value");
    repeat (3) idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule